// File: doc/BRIEF.md
# Triple Match-Overflow Timer

This block is a memory-mapped timer peripheral with three independent 32-bit counters. Each counter has a current count, a reload value and two compare values. It can count up or down. It advances either on every system clock or only on cycles where an external tick qualifier is high. When a counter wraps, it reloads and flags an overflow. When a counter lands on either compare value, it flags a match. The flags collect in one shared sticky status word. A shared mask word and a per-timer interrupt-enable bit reduce them to one interrupt line per timer.

Software uses it in two ways. For periodic ticks, an up-counter is loaded with `0xFFFFFFFF-(P-1)` in both count and reload, so it overflows every P advances. For one-shot delays, the current count plus the delay is written into compare 1. The register bus is a simple single-cycle interface: a write strobe, a byte address, write data, and combinational read data.

Top module: `tmr_triple`

## Requirements
- R1: After a synchronous reset, every register reads zero, all counters are stopped and all three interrupt lines are low.
- R2: Register map. Timer n (n = 0, 1, 2) has its count, reload, compare 1 and compare 2 at byte addresses 0x10·n + 0x0, 0x4, 0x8 and 0xC, each 32 bits and read/write. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). Any other address, including one that is not word aligned, reads zero and ignores writes.
- R3: A counter advances only while its enable bit (control bit 3n) is 1. A stopped counter holds its value, and a bus write to its count register sets the starting value.
- R4: When direction bit 9+n is 0, the counter increments. An advance from 0xFFFFFFFF loads the reload value and sets status bit 3n+2 on the same clock edge. With count and reload both set to 0xFFFFFFFF-(P-1), the overflow bit therefore rises exactly P advances after enabling, and again every P advances after that.
- R5: When direction bit 9+n is 1, the counter decrements. An advance from 0 loads the reload value and sets status bit 3n+2 on the same edge.
- R6: On an advance whose resulting count equals compare 1, status bit 3n is set on that same edge. If the resulting count equals compare 2, status bit 3n+1 is set. A bus write to the count register never raises a match.
- R7: When clock-select bit 3n+1 is 1, the counter advances only on clock edges where `ext_tick` is high. When the bit is 0, it advances on every edge.
- R8: A status bit is set by its event whatever the mask holds, and stays set until software changes it. A write to 0x34 replaces the whole status word, except that events on the same edge still set their bits.
- R9: `irq[n]` is high exactly when interrupt-enable bit 3n+2 is 1 and at least one of status bits 3n..3n+2 has its mask bit set to 1. It follows register state with no added cycle.
- R10: A bus write to a count register takes priority over an advance on the same edge. The next value is the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External tick qualifier for timers with clock select set |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 3 | One interrupt line per timer |

## Verification
Every register update lands on the same rising edge that performs it: a write, an advance, a reload or a status flag. Read data and the interrupt lines are combinational from those registers. A result due on advance k after the enabling write is therefore visible in the half cycle after the k-th following rising edge. The bench drives all stimulus at falling edges and counts falling edges from the enabling write. It checks one cycle before each due edge that the flag is still clear, and on the due edge that it has risen, so that an early or late overflow or match shows up as a failed check. Interrupt lines are sampled in the same half cycle as the status word that drives them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned TMR_N   = 3;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned CTRL_W  = 4 * TMR_N;
    localparam int unsigned EVT_W   = 3 * TMR_N;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 6'h30;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 6'h34;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 6'h38;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CMP1   = 2'd2,
        REG_CMP2   = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic run;
        logic ext_sel;
        logic irq_en;
        logic dn;
    } tmr_ctl_t;

    // bit 0 = match 1, bit 1 = match 2, bit 2 = overflow
    typedef struct packed {
        logic ovf;
        logic hit2;
        logic hit1;
    } tmr_evt_t;

    function automatic tmr_ctl_t ctl_of(input logic [CTRL_W-1:0] w, input int unsigned n);
        tmr_ctl_t c;
        c.run     = w[3*n];
        c.ext_sel = w[3*n+1];
        c.irq_en  = w[3*n+2];
        c.dn      = w[3*TMR_N+n];
        return c;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_ctl_t      ctl,
    input  logic          ext_tick,
    input  logic          wr_en,
    input  tmr_reg_e      wr_sel,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] rld_o,
    output logic [CW-1:0] cmp1_o,
    output logic [CW-1:0] cmp2_o,
    output tmr_evt_t      evt_o
);

    logic [CW-1:0] cnt_q, rld_q, c1_q, c2_q, cnt_nxt;
    logic          adv, wrap, cnt_we;

    always_comb begin
        cnt_we  = wr_en && (wr_sel == REG_COUNT);
        adv     = ctl.run && (!ctl.ext_sel || ext_tick);
        wrap    = ctl.dn ? (cnt_q == '0) : (cnt_q == '1);
        if (wrap)
            cnt_nxt = rld_q;
        else if (ctl.dn)
            cnt_nxt = cnt_q - CW'(1);
        else
            cnt_nxt = cnt_q + CW'(1);
        evt_o.ovf  = adv && !cnt_we && wrap;
        evt_o.hit1 = adv && !cnt_we && (cnt_nxt == c1_q);
        evt_o.hit2 = adv && !cnt_we && (cnt_nxt == c2_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            c1_q  <= '0;
            c2_q  <= '0;
        end else begin
            if (cnt_we)
                cnt_q <= wdata;
            else if (adv)
                cnt_q <= cnt_nxt;
            if (wr_en && wr_sel == REG_RELOAD) rld_q <= wdata;
            if (wr_en && wr_sel == REG_CMP1)   c1_q  <= wdata;
            if (wr_en && wr_sel == REG_CMP2)   c2_q  <= wdata;
        end
    end

    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign cmp1_o = c1_q;
    assign cmp2_o = c2_q;

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !cnt_we) |=> (cnt_q == $past(cnt_q)));

    // R7
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.ext_sel && !ext_tick && !cnt_we) |=> $stable(cnt_q));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !cnt_we && !ctl.dn && cnt_q == '1) |=> (cnt_q == $past(rld_q)));

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !cnt_we && ctl.dn && cnt_q == '0) |=> (cnt_q == $past(rld_q)));

    // R10
    cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/tmr_status.sv
module tmr_status
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             st_we,
    input  logic             mk_we,
    input  logic [EVT_W-1:0] wdata,
    input  logic [TMR_N-1:0] ie,
    output logic [EVT_W-1:0] status_o,
    output logic [EVT_W-1:0] mask_o,
    output logic [TMR_N-1:0] irq
);

    logic [EVT_W-1:0] status_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (st_we ? wdata : status_q) | evt;
            if (mk_we) mask_q <= wdata;
        end
    end

    for (genvar g = 0; g < TMR_N; g++) begin : g_irq
        assign irq[g] = ie[g] && |(status_q[3*g +: 3] & mask_q[3*g +: 3]);

        // R9
        irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
            (ie[g] && !mk_we && |(evt[3*g +: 3] & mask_q[3*g +: 3])) |=> (irq[g] || !ie[g]));
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !st_we |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/tmr_triple.sv
module tmr_triple
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic [TMR_N-1:0]  irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [EVT_W-1:0]  evt_all, status_w, mask_w;
    logic [TMR_N-1:0]  ie_w;
    logic [CW-1:0]     cnt_a [TMR_N];
    logic [CW-1:0]     rld_a [TMR_N];
    logic [CW-1:0]     c1_a  [TMR_N];
    logic [CW-1:0]     c2_a  [TMR_N];
    logic              aligned;

    assign aligned = (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
        tmr_ctl_t ctl;
        tmr_evt_t evt;
        logic     bank_we;

        assign ctl     = ctl_of(ctrl_q, g);
        assign ie_w[g] = ctl.irq_en;
        assign bank_we = bus_wr && aligned && (bus_addr[5:4] == 2'(g));
        assign evt_all[3*g +: 3] = evt;

        tmr_channel #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .ext_tick (ext_tick),
            .wr_en    (bank_we),
            .wr_sel   (tmr_reg_e'(bus_addr[3:2])),
            .wdata    (bus_wdata),
            .cnt_o    (cnt_a[g]),
            .rld_o    (rld_a[g]),
            .cmp1_o   (c1_a[g]),
            .cmp2_o   (c2_a[g]),
            .evt_o    (evt)
        );
    end

    tmr_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_all),
        .st_we    (bus_wr && bus_addr == ADDR_STAT),
        .mk_we    (bus_wr && bus_addr == ADDR_MASK),
        .wdata    (bus_wdata[EVT_W-1:0]),
        .ie       (ie_w),
        .status_o (status_w),
        .mask_o   (mask_w),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned && bus_addr[5:4] < 2'(TMR_N)) begin
            case (tmr_reg_e'(bus_addr[3:2]))
                REG_COUNT:  bus_rdata = cnt_a[bus_addr[5:4]];
                REG_RELOAD: bus_rdata = rld_a[bus_addr[5:4]];
                REG_CMP1:   bus_rdata = c1_a[bus_addr[5:4]];
                REG_CMP2:   bus_rdata = c2_a[bus_addr[5:4]];
                default:    bus_rdata = '0;
            endcase
        end else if (bus_addr == ADDR_CTRL) begin
            bus_rdata = CW'(ctrl_q);
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata = CW'(status_w);
        end else if (bus_addr == ADDR_MASK) begin
            bus_rdata = CW'(mask_w);
        end
    end

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[2] == 1'b0) |-> (irq[0] == 1'b0));

endmodule

// File: tb/tb_tmr_triple.sv
module tb_tmr_triple;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    localparam int unsigned PER = 10;

    always #2.5 clk = ~clk;

    tmr_triple dut (
        .clk(clk), .rst(rst), .ext_tick(ext_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a <= 'h38; a += 4) begin
            rd(6'(a), d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(6'h14, 32'hA5A5_0001);
        wr(6'h28, 32'h1234_5678);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h14, d); chk("R2 timer1 reload", d, 32'hA5A5_0001);
        rd(6'h28, d); chk("R2 timer2 compare1", d, 32'h1234_5678);
        rd(6'h3C, d); chk("R2 unmapped read", d, 32'h0);
        rd(6'h04, d); chk("R2 unaligned write ignored", d, 32'h0);
        rd(6'h05, d); chk("R2 unaligned read", d, 32'h0);
        wr(6'h14, 32'h0); wr(6'h28, 32'h0);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        logic [31:0] ld;
        ld = 32'hFFFF_FFFF - (PER - 1);
        wr(6'h34, 32'h0);
        wr(6'h38, 32'h004);
        wr(6'h00, ld);
        wr(6'h04, ld);
        wr(6'h30, 32'h005);
        tick(PER - 1);
        rd(6'h34, d); chk("R4 no overflow before period", d, 32'h0);
        chk("R9 irq low before overflow", 32'(irq), 32'h0);
        tick(1);
        rd(6'h34, d); chk("R4 overflow at period", d, 32'h004);
        rd(6'h00, d); chk("R4 reloaded count", d, ld);
        chk("R9 irq on masked overflow", 32'(irq), 32'h1);
        wr(6'h34, 32'h0);
        chk("R8 status write clears irq", 32'(irq), 32'h0);
        tick(PER - 2);
        rd(6'h34, d); chk("R4 second period not early", d, 32'h0);
        tick(1);
        rd(6'h34, d); chk("R4 second overflow spacing", d, 32'h004);
        wr(6'h30, 32'h0);
        rd(6'h00, d);
        tick(5);
        begin
            logic [31:0] d2;
            rd(6'h00, d2); chk("R3 stopped count holds", d2, d);
        end
        wr(6'h38, 32'h0);
        wr(6'h34, 32'h0);
    endtask

    task automatic t_compare;
        logic [31:0] d;
        wr(6'h10, 32'd100);
        wr(6'h18, 32'd105);
        wr(6'h1C, 32'd103);
        rd(6'h10, d); chk("R3 count written while stopped", d, 32'd100);
        wr(6'h30, 32'h008);
        tick(2);
        rd(6'h34, d); chk("R6 no match yet", d, 32'h0);
        tick(1);
        rd(6'h34, d); chk("R6 compare2 match bit 4", d, 32'h010);
        tick(2);
        rd(6'h34, d); chk("R6 compare1 match bit 3 with mask zero (R8)", d, 32'h018);
        rd(6'h10, d); chk("R6 count at compare1", d, 32'd105);
        tick(4);
        rd(6'h34, d); chk("R8 status sticky", d, 32'h018);
        wr(6'h30, 32'h0);
        wr(6'h10, 32'd108);
        rd(6'h34, d); chk("R6 count write raises no match", d, 32'h018);
        wr(6'h34, 32'h0);
    endtask

    task automatic t_down;
        logic [31:0] d;
        wr(6'h28, 32'h1000);
        wr(6'h2C, 32'h1000);
        wr(6'h20, 32'd3);
        wr(6'h24, 32'd7);
        wr(6'h30, 32'h840);
        tick(3);
        rd(6'h20, d); chk("R5 down count reaches zero", d, 32'd0);
        rd(6'h34, d); chk("R5 no underflow yet", d, 32'h0);
        tick(1);
        rd(6'h20, d); chk("R5 underflow reload", d, 32'd7);
        rd(6'h34, d); chk("R5 overflow bit 8", d, 32'h100);
        tick(1);
        rd(6'h20, d); chk("R5 decrement after reload", d, 32'd6);
        wr(6'h30, 32'h0);
        wr(6'h34, 32'h0);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        wr(6'h00, 32'd50);
        wr(6'h30, 32'h003);
        tick(5);
        rd(6'h00, d); chk("R7 no advance without tick", d, 32'd50);
        ext_tick = 1'b1; tick(1); ext_tick = 1'b0;
        rd(6'h00, d); chk("R7 one tick one advance", d, 32'd51);
        tick(3);
        rd(6'h00, d); chk("R7 hold after tick", d, 32'd51);
        ext_tick = 1'b1; tick(4);
        rd(6'h00, d); chk("R7 four ticks", d, 32'd55);
        wr(6'h00, 32'd200);
        rd(6'h00, d); chk("R10 write beats advance", d, 32'd200);
        tick(1);
        rd(6'h00, d); chk("R10 advance after write", d, 32'd201);
        ext_tick = 1'b0;
        wr(6'h30, 32'h0);
        wr(6'h34, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(6'h34, 32'h1FF);
        rd(6'h34, d); chk("R8 status write replaces", d, 32'h1FF);
        wr(6'h30, 32'h124);
        chk("R9 mask zero keeps irq low", 32'(irq), 32'h0);
        wr(6'h38, 32'h1FF);
        chk("R9 all lines with full mask", 32'(irq), 32'h7);
        wr(6'h30, 32'h0);
        chk("R9 interrupt enable off", 32'(irq), 32'h0);
        wr(6'h30, 32'h124);
        wr(6'h38, 32'h010);
        wr(6'h34, 32'h008);
        chk("R9 unmasked bit only", 32'(irq), 32'h0);
        wr(6'h34, 32'h010);
        chk("R9 timer1 match2 line", 32'(irq), 32'h2);
        wr(6'h34, 32'h0);
        rd(6'h34, d); chk("R8 write zero clears", d, 32'h0);
        wr(6'h30, 32'h0);
        wr(6'h38, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_periodic();
        t_compare();
        t_down();
        t_ext();
        t_mask();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule